// File: doc/BRIEF.md
# Port Direction Controller with Peripheral Override

This block holds the direction settings for an 8-pin general-purpose port and produces the output enable for each pin. Software writes an 8-bit direction word over a simple register bus. A 0 bit leaves its pin as an input, and a 1 bit lets the pin drive.

Three serial peripherals share the port: two asynchronous channels and one synchronous controller. An enabled peripheral can take over the pins it uses. Each peripheral follows its own rule:

- **Asynchronous receive pins.** An enabled receiver forces its pin to input.
- **Asynchronous transmit pins.** An enabled transmitter forces its pin to output.
- **Synchronous controller pins 4 to 6.** The controller can only narrow what the register allows. A pin it wants as an output drives only if the pin's register bit is also set.
- **Pin 7 (select pin).** In slave mode pin 7 is always the select input. In master mode the register bit chooses between a fault input and an output.

The output-enable vector is combinational from the register and the status inputs. Overrides never change the stored register bits or what reads return.

Pin assignment:
- Pins 0 and 1 are the receive and transmit pins of asynchronous channel 0.
- Pins 2 and 3 are the receive and transmit pins of asynchronous channel 1.
- Pins 4 to 7 belong to the synchronous controller, in the order data in, data out, clock, select.

Top module: `portdir_ctrl`

## Requirements
- R1: A write with `bus_wr`=1 and `bus_addr`=16'h00D7 stores `bus_wdata` in the direction register at that clock edge. While `bus_addr`=16'h00D7, `bus_rdata` shows the stored value.
- R2: A synchronous reset (`rst`=1 at a clock edge) clears the direction register to 8'h00. While reset is held and no peripheral is enabled, `pin_oe`=8'h00.
- R3: For a pin that no enabled peripheral claims, `pin_oe[i]` equals direction bit i.
- R4: When `async0_rx_en`=1, `pin_oe[0]`=0. When `async1_rx_en`=1, `pin_oe[2]`=0. Both hold whatever the register bit.
- R5: When `async0_tx_en`=1, `pin_oe[1]`=1. When `async1_tx_en`=1, `pin_oe[3]`=1. Both hold whatever the register bit.
- R6: When `sync_en`=1, each pin k in 4..6 with `sync_want_out[k-4]`=0 has `pin_oe[k]`=0, whatever its register bit.
- R7: When `sync_en`=1, each pin k in 4..6 with `sync_want_out[k-4]`=1 has `pin_oe[k]` equal to direction bit k.
- R8: When `sync_en`=1 and `sync_master`=0 (slave mode), `pin_oe[7]`=0, whatever direction bit 7 and `sync_want_out[3]` hold.
- R9: When `sync_en`=1 and `sync_master`=1, `pin_oe[7]` equals direction bit 7. A 0 makes pin 7 the fault input and a 1 makes it an output. `sync_want_out[3]` has no effect.
- R10: Overrides never change the register. With any peripheral status, a read at 16'h00D7 returns the last value written.
- R11: A write to any other address leaves the register unchanged. A read at any other address returns 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| async0_rx_en | input | 1 | Channel 0 receiver enabled, two-wire |
| async0_tx_en | input | 1 | Channel 0 transmitter enabled, two-wire |
| async1_rx_en | input | 1 | Channel 1 receiver enabled, two-wire |
| async1_tx_en | input | 1 | Channel 1 transmitter enabled, two-wire |
| sync_en | input | 1 | Synchronous controller enabled |
| sync_master | input | 1 | 1 = master mode, 0 = slave mode |
| sync_want_out | input | 4 | Wanted direction for pins 4..7, 1 = output |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The bench targets the following corner cases and the failure each would show:

- **Gating of synchronous output pins.** A design that let the controller drive a pin whose register bit is 0 would raise `pin_oe` on pins 4 to 6 with a zero register.
- **The two modes of pin 7.** A design that honoured direction bit 7 in slave mode would drive the select input. A design that followed `sync_want_out[3]` in master mode would break the fault-input choice.
- **Overrides written back to the register.** A design that stored overridden values would return changed read data once the peripherals are disabled.
- **Stray bus traffic.** A design with a loose address decode would let writes to nearby addresses corrupt the register.

// File: rtl/portdir_pkg.sv
package portdir_pkg;
  localparam int PORT_W = 8;
  localparam int SYNC_W = 4;

  // pin ownership map
  localparam int PIN_A0_RX = 0;
  localparam int PIN_A0_TX = 1;
  localparam int PIN_A1_RX = 2;
  localparam int PIN_A1_TX = 3;
  localparam int PIN_SYNC0 = 4;
  localparam int PIN_SEL   = 7;

  typedef enum logic [1:0] {
    RULE_NONE      = 2'd0,
    RULE_FORCE_IN  = 2'd1,
    RULE_FORCE_OUT = 2'd2,
    RULE_GATED     = 2'd3
  } pin_rule_e;
endpackage

// File: rtl/portdir_reg.sv
module portdir_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h00D7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dir_q
);
  logic hit;

  assign hit = (addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (wr && hit) begin
      dir_q <= wdata;
    end
  end

  assign rdata = hit ? dir_q : '0;

  // R1
  write_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == REG_ADDR) |=> (dir_q == $past(wdata)));

  // R11
  foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr != REG_ADDR) |=> (dir_q == $past(dir_q)));

  // R11
  foreign_read_chk: assert property (@(posedge clk) disable iff (rst)
    (addr != REG_ADDR) |-> (rdata == '0));
endmodule

// File: rtl/portdir_owner.sv
module portdir_owner
  import portdir_pkg::*;
(
  input  logic              a0_rx_en,
  input  logic              a0_tx_en,
  input  logic              a1_rx_en,
  input  logic              a1_tx_en,
  input  logic              sync_en,
  input  logic              sync_master,
  input  logic [SYNC_W-1:0] sync_want,
  output pin_rule_e         rule [PORT_W]
);
  always_comb begin
    for (int i = 0; i < PORT_W; i++) rule[i] = RULE_NONE;
    if (a0_rx_en) rule[PIN_A0_RX] = RULE_FORCE_IN;
    if (a0_tx_en) rule[PIN_A0_TX] = RULE_FORCE_OUT;
    if (a1_rx_en) rule[PIN_A1_RX] = RULE_FORCE_IN;
    if (a1_tx_en) rule[PIN_A1_TX] = RULE_FORCE_OUT;
    if (sync_en) begin
      for (int k = 0; k < SYNC_W - 1; k++) begin
        rule[PIN_SYNC0 + k] = sync_want[k] ? RULE_GATED : RULE_FORCE_IN;
      end
      // select pin: slave forces input, master leaves the register in charge
      rule[PIN_SEL] = sync_master ? RULE_NONE : RULE_FORCE_IN;
    end
  end
endmodule

// File: rtl/portdir_pin.sv
module portdir_pin
  import portdir_pkg::*;
(
  input  pin_rule_e rule,
  input  logic      dir_bit,
  output logic      oe
);
  always_comb begin
    unique case (rule)
      RULE_FORCE_IN:  oe = 1'b0;
      RULE_FORCE_OUT: oe = 1'b1;
      RULE_GATED:     oe = dir_bit;
      default:        oe = dir_bit;
    endcase
  end
endmodule

// File: rtl/portdir_ctrl.sv
module portdir_ctrl
  import portdir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'h00D7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              async0_rx_en,
  input  logic              async0_tx_en,
  input  logic              async1_rx_en,
  input  logic              async1_tx_en,
  input  logic              sync_en,
  input  logic              sync_master,
  input  logic [SYNC_W-1:0] sync_want_out,
  output logic [PORT_W-1:0] pin_oe
);
  logic [PORT_W-1:0] dir_q;
  pin_rule_e         rule [PORT_W];

  portdir_reg #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (PORT_W),
    .REG_ADDR(DIR_ADDR)
  ) u_reg (
    .clk  (clk),
    .rst  (rst),
    .addr (bus_addr),
    .wr   (bus_wr),
    .wdata(bus_wdata),
    .rdata(bus_rdata),
    .dir_q(dir_q)
  );

  portdir_owner u_owner (
    .a0_rx_en   (async0_rx_en),
    .a0_tx_en   (async0_tx_en),
    .a1_rx_en   (async1_rx_en),
    .a1_tx_en   (async1_tx_en),
    .sync_en    (sync_en),
    .sync_master(sync_master),
    .sync_want  (sync_want_out),
    .rule       (rule)
  );

  for (genvar g = 0; g < PORT_W; g++) begin : g_pin
    portdir_pin u_pin (
      .rule   (rule[g]),
      .dir_bit(dir_q[g]),
      .oe     (pin_oe[g])
    );
  end

  // R4
  rx_input_chk: assert property (@(posedge clk) disable iff (rst)
    (async0_rx_en || async1_rx_en) |->
      (!(async0_rx_en && pin_oe[PIN_A0_RX]) && !(async1_rx_en && pin_oe[PIN_A1_RX])));

  // R5
  tx_output_chk: assert property (@(posedge clk) disable iff (rst)
    (async0_tx_en || async1_tx_en) |->
      ((!async0_tx_en || pin_oe[PIN_A0_TX]) && (!async1_tx_en || pin_oe[PIN_A1_TX])));

  // R6
  sync_in_chk: assert property (@(posedge clk) disable iff (rst)
    sync_en |-> ((pin_oe[PIN_SEL-1:PIN_SYNC0] & ~sync_want_out[SYNC_W-2:0]) == '0));

  // R7
  sync_gate_chk: assert property (@(posedge clk) disable iff (rst)
    sync_en |-> ((pin_oe[PIN_SEL-1:PIN_SYNC0] & ~bus_rdata_gate()) == '0));

  // R8
  slave_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_en && !sync_master) |-> !pin_oe[PIN_SEL]);

  // R10
  override_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !($past(bus_wr) && $past(bus_addr) == DIR_ADDR) && bus_addr == DIR_ADDR
      && $past(bus_addr) == DIR_ADDR |-> $stable(bus_rdata));

  function automatic logic [SYNC_W-2:0] bus_rdata_gate();
    return dir_q[PIN_SEL-1:PIN_SYNC0];
  endfunction
endmodule

// File: tb/portdir_ctrl_tb.sv
`timescale 1ns/1ps
module portdir_ctrl_tb;
  localparam logic [15:0] DIR_ADDR = 16'h00D7;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        a0rx, a0tx, a1rx, a1tx, sen, smst;
  logic [3:0]  swant;
  logic [7:0]  pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] shadow;

  always #4 clk = ~clk;

  portdir_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .async0_rx_en(a0rx), .async0_tx_en(a0tx),
    .async1_rx_en(a1rx), .async1_tx_en(a1tx),
    .sync_en(sen), .sync_master(smst), .sync_want_out(swant),
    .pin_oe(pin_oe)
  );

  function automatic logic [7:0] model_oe(logic [7:0] d);
    logic [7:0] o;
    o = d;
    if (a0rx) o[0] = 1'b0;
    if (a0tx) o[1] = 1'b1;
    if (a1rx) o[2] = 1'b0;
    if (a1tx) o[3] = 1'b1;
    if (sen) begin
      for (int k = 0; k < 3; k++) o[4+k] = swant[k] & d[4+k];
      o[7] = smst ? d[7] : 1'b0;
    end
    return o;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle_status();
    a0rx = 0; a0tx = 0; a1rx = 0; a1tx = 0; sen = 0; smst = 0; swant = 0;
  endtask

  task automatic wr_reg(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(posedge clk);
    if (a == DIR_ADDR) shadow = d;
    @(negedge clk);
    bus_wr = 0; bus_addr = DIR_ADDR;
  endtask

  task automatic settle_check(string tag);
    #1;
    check(tag, pin_oe, model_oe(shadow));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; bus_addr = DIR_ADDR; bus_wr = 0; bus_wdata = 0; shadow = 0;
    idle_status();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 rdata after reset", bus_rdata, 8'h00);
    check("R2 oe after reset", pin_oe, 8'h00);
    rst = 0;

    wr_reg(DIR_ADDR, 8'hA5);
    #1 check("R1 readback", bus_rdata, 8'hA5);
    check("R3 no owner oe", pin_oe, 8'hA5);

    wr_reg(16'h00D6, 8'h3C);
    #1 check("R11 write other addr ignored", bus_rdata, 8'hA5);
    bus_addr = 16'h00D8; #1;
    check("R11 read other addr", bus_rdata, 8'h00);
    bus_addr = DIR_ADDR;

    wr_reg(DIR_ADDR, 8'hFF);
    a0rx = 1; a1rx = 1; #1;
    check("R4 rx forced input", pin_oe & 8'h05, 8'h00);
    idle_status();
    wr_reg(DIR_ADDR, 8'h00);
    a0tx = 1; a1tx = 1; #1;
    check("R5 tx forced output", pin_oe, 8'h0A);
    idle_status();

    wr_reg(DIR_ADDR, 8'hF0);
    sen = 1; smst = 1; swant = 4'b0000; #1;
    check("R6 sync wants input", pin_oe, 8'h80);
    wr_reg(DIR_ADDR, 8'h50);
    swant = 4'b0111; #1;
    check("R7 sync gated by dir", pin_oe, 8'h50);

    wr_reg(DIR_ADDR, 8'h80);
    smst = 0; swant = 4'b1000; #1;
    check("R8 slave select input", pin_oe, 8'h00);
    smst = 1; swant = 4'b0000; #1;
    check("R9 master dir7=1 output", pin_oe[7], 1'b1);
    wr_reg(DIR_ADDR, 8'h00);
    swant = 4'b1000; #1;
    check("R9 master dir7=0 fault input", pin_oe[7], 1'b0);

    wr_reg(DIR_ADDR, 8'h6B);
    a0rx = 1; a0tx = 1; a1rx = 1; a1tx = 1; sen = 1; smst = 0; swant = 0; #1;
    check("R10 read under override", bus_rdata, 8'h6B);
    idle_status(); #1;
    check("R10 oe after override release", pin_oe, 8'h6B);

    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      {a0rx, a0tx, a1rx, a1tx, sen, smst} = 6'($urandom);
      swant = 4'($urandom);
      bus_wr = $urandom_range(0, 2) == 0;
      bus_addr = ($urandom_range(0, 3) == 0) ? 16'($urandom) : DIR_ADDR;
      bus_wdata = 8'($urandom);
      #1;
      check("R3 R4 R5 R6 R7 R8 R9 random oe", pin_oe, model_oe(shadow));
      check("R10 R11 random rdata", bus_rdata,
            (bus_addr == DIR_ADDR) ? shadow : 8'h00);
      @(posedge clk);
      if (bus_wr && bus_addr == DIR_ADDR) shadow = bus_wdata;
    end

    @(negedge clk);
    bus_wr = 0; rst = 1; idle_status();
    @(posedge clk); shadow = 0;
    @(negedge clk);
    check("R2 reset clears register", pin_oe, 8'h00);
    rst = 0;
    settle_check("R3 after reset release");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule